// File: doc/BRIEF.md
# One-Wire Search Responder

This block is the device-side protocol engine that lets a slave with a fixed identifier take part in a one-wire bus search. It watches the shared open-drain line and recognises a long low pulse from the master as a bus reset. It answers that reset with a presence pulse. It then takes in a command byte through eight write slots. If the byte is the search command, the block walks its identifier one position at a time.

For each position the block answers two read slots: first with its own bit, then with the complement of that bit. It then samples the master's direction bit in a write slot. If the direction bit differs from its own bit, the block drops out of the search and leaves the line released until the next reset. If it matches at every position, the block has been singled out and stays selected.

The line is driven only by pulling it low (`line_pull`). A 0 is sent by pulling and a 1 by leaving the line alone, so the bus carries the AND of all drivers. Every timing value is written in microseconds and converted to clock cycles through `CLK_PER_US`.

Top module: `owire_search_slave`

## Requirements
- R1: A low level on the line lasting at least `RESET_US` is a bus reset. The block answers by pulling the line low starting `PRES_GAP_US` after the line rises, for `PRES_LEN_US`.
- R2: A logical 0 is sent by asserting `line_pull` and a logical 1 by leaving it deasserted. The presence pulse and the read-slot drive never overlap.
- R3: After a presence pulse, eight write slots are taken as a command byte, least significant bit first. The value 0xF0 starts a search, and `selected` rises after the eighth slot.
- R4: Any other command byte leaves `selected` low and the line released for every later slot until the next reset.
- R5: In the first read slot of search position i (i counting from 0, position 0 being `id_i[0]`), the block sends `id_i[i]`.
- R6: In the second read slot of position i, the block sends the complement of `id_i[i]`.
- R7: The write slot of each position is sampled `SAMPLE_US` after the master's falling edge, low meaning 0 and high meaning 1. If the sampled bit differs from `id_i[i]`, `selected` falls and the line stays released until the next reset.
- R8: If the sampled bit matches at all `ID_W` positions, `selected` stays high and the block leaves the line released for every further slot until the next reset.
- R9: When sending 0 in a read slot, the block holds the line low for `HOLD_US` after the master's falling edge and then releases it.
- R10: A bus reset in the middle of a search aborts it. `selected` goes low, a new presence pulse follows, and a new command is required.
- R11: While `rst_n` is low on a clock edge, the block returns to idle with `line_pull` and `selected` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| line_in | input | 1 | Sampled level of the shared line (asynchronous, synchronised inside) |
| id_i | input | ID_W | Identifier of this slave; bit 0 is searched first |
| line_pull | output | 1 | Pull-low enable for the open-drain line driver |
| selected | output | 1 | High while the block takes part in a search and after it has been singled out |

## Verification
A wrong position counter or a wrong compare shows on the line within one read slot: the bit or the complement disagrees with the identifier. A wrong compare also shows within one write slot, as an early or missing fall of `selected`. A broken command shift shows after the eighth write slot, because `selected` fails to rise for 0xF0 or rises for another byte. A bad reset detector or presence timer shows within a single reset sequence, as a line level that is wrong at the sampling points about 10, 80 and 200 microseconds after the master releases the line.

// File: rtl/owire_search_pkg.sv
// Package: shared state encoding and protocol constants for the one-wire
// search responder. Assumes no other package defines these names.
package owire_search_pkg;

    // Protocol state of the responder
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RST_LOW,
        ST_PRES_GAP,
        ST_PRES_DRV,
        ST_CMD,
        ST_BIT,
        ST_CMP,
        ST_WR,
        ST_FOUND,
        ST_OUT
    } ow_state_e;

    // Command byte value that starts an identifier search
    localparam logic [7:0] SEARCH_CMD = 8'hF0;

endpackage

// File: rtl/owire_line_mon.sv
// Line monitor: synchronises the line level and reports its edges. It also
// reports a bus reset once the line has been low for RESET_CYC cycles.
// Assumes line_in may change at any time relative to clk.
module owire_line_mon #(
    parameter int RESET_CYC = 960
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_in,
    output logic line_s,
    output logic fall,
    output logic rise,
    output logic reset_det
);
    localparam int CW = $clog2(RESET_CYC + 1);
    localparam logic [CW-1:0] LIM     = CW'(RESET_CYC);
    localparam logic [CW-1:0] LIM_M1  = CW'(RESET_CYC - 1);

    logic [1:0]    sync_q;
    logic          prev_q;
    logic [CW-1:0] low_cnt;

    // Two-stage synchroniser and previous-level register for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= 2'b11;
            prev_q <= 1'b1;
        end else begin
            sync_q <= {sync_q[0], line_in};
            prev_q <= sync_q[1];
        end
    end

    // Saturating count of consecutive low cycles
    always_ff @(posedge clk) begin
        if (!rst_n || sync_q[1]) begin
            low_cnt <= '0;
        end else if (low_cnt != LIM) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    // Edge and reset indications
    always_comb begin
        line_s    = sync_q[1];
        fall      = prev_q & ~sync_q[1];
        rise      = ~prev_q & sync_q[1];
        reset_det = ~sync_q[1] && (low_cnt == LIM_M1);
    end
endmodule

// File: rtl/owire_slot.sv
// Slot engine: starts a time slot on a falling edge while armed. It holds the
// line low for HOLD_CYC cycles when the latched transmit bit is 0, and samples
// the line SAMPLE_CYC cycles after the slot start. Assumes a slot is never
// shorter than the larger of the two windows.
module owire_slot #(
    parameter int SAMPLE_CYC = 60,
    parameter int HOLD_CYC   = 60
) (
    input  logic clk,
    input  logic rst_n,
    input  logic abort,
    input  logic arm,
    input  logic fall,
    input  logic line_s,
    input  logic tx_en,
    input  logic tx_bit,
    output logic pull,
    output logic done,
    output logic rx_bit
);
    localparam int END_CYC = (SAMPLE_CYC > HOLD_CYC) ? SAMPLE_CYC : HOLD_CYC;
    localparam int TW      = $clog2(END_CYC + 1);
    localparam logic [TW-1:0] T_END  = TW'(END_CYC - 1);
    localparam logic [TW-1:0] T_SMP  = TW'(SAMPLE_CYC - 1);
    localparam logic [TW-1:0] T_HOLD = TW'(HOLD_CYC);

    logic          active;
    logic [TW-1:0] t_q;
    logic          tx0_q;

    // Slot timer: start on an armed falling edge, stop at the end of the window
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            active <= 1'b0;
            t_q    <= '0;
            tx0_q  <= 1'b0;
        end else if (!active) begin
            t_q <= '0;
            if (arm && fall) begin
                active <= 1'b1;
                tx0_q  <= tx_en & ~tx_bit;
            end
        end else begin
            t_q <= t_q + 1'b1;
            if (t_q == T_END) begin
                active <= 1'b0;
            end
        end
    end

    // Sample point: capture the line and flag slot completion
    always_ff @(posedge clk) begin
        if (!rst_n || abort) begin
            done   <= 1'b0;
            rx_bit <= 1'b1;
        end else begin
            done <= active && (t_q == T_SMP);
            if (active && (t_q == T_SMP)) begin
                rx_bit <= line_s;
            end
        end
    end

    // Drive low while sending a 0 inside the hold window
    always_comb begin
        pull = active && tx0_q && (t_q < T_HOLD);
    end
endmodule

// File: rtl/owire_search_fsm.sv
// Search controller: sequences the presence pulse, the command byte and the
// bit / complement / direction triplets of the identifier search. Assumes
// slot_done pulses once per slot, with slot_rx valid in the same cycle.
module owire_search_fsm
    import owire_search_pkg::*;
#(
    parameter int ID_W         = 64,
    parameter int PRES_GAP_CYC = 60,
    parameter int PRES_LEN_CYC = 240
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [ID_W-1:0] id_i,
    input  logic            reset_det,
    input  logic            rise,
    input  logic            slot_done,
    input  logic            slot_rx,
    output ow_state_e       state,
    output logic            slot_arm,
    output logic            tx_en,
    output logic            tx_bit,
    output logic            pres_pull,
    output logic            selected
);
    localparam int PW  = (ID_W > 1) ? $clog2(ID_W) : 1;
    localparam int PMX = (PRES_GAP_CYC > PRES_LEN_CYC) ? PRES_GAP_CYC : PRES_LEN_CYC;
    localparam int CW  = $clog2(PMX + 1);
    localparam logic [CW-1:0] GAP_LAST = CW'(PRES_GAP_CYC - 1);
    localparam logic [CW-1:0] LEN_LAST = CW'(PRES_LEN_CYC - 1);
    localparam logic [PW-1:0] POS_LAST = PW'(ID_W - 1);

    logic [CW-1:0] cnt_q;
    logic [PW-1:0] pos_q;
    logic [7:0]    cmd_q;
    logic [2:0]    cmd_cnt;
    logic          own_bit;
    logic [7:0]    cmd_next;

    // Identifier bit at the current search position and the next command value
    always_comb begin
        own_bit  = id_i[pos_q];
        cmd_next = {slot_rx, cmd_q[7:1]};
    end

    // Protocol state machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cnt_q   <= '0;
            pos_q   <= '0;
            cmd_q   <= '0;
            cmd_cnt <= '0;
        end else if (reset_det) begin
            state <= ST_RST_LOW;
            cnt_q <= '0;
        end else begin
            unique case (state)
                ST_RST_LOW: begin
                    if (rise) begin
                        state <= ST_PRES_GAP;
                        cnt_q <= '0;
                    end
                end
                ST_PRES_GAP: begin
                    if (cnt_q == GAP_LAST) begin
                        state <= ST_PRES_DRV;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_PRES_DRV: begin
                    if (cnt_q == LEN_LAST) begin
                        state   <= ST_CMD;
                        cnt_q   <= '0;
                        cmd_cnt <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                ST_CMD: begin
                    if (slot_done) begin
                        cmd_q   <= cmd_next;
                        cmd_cnt <= cmd_cnt + 1'b1;
                        if (cmd_cnt == 3'd7) begin
                            pos_q <= '0;
                            state <= (cmd_next == SEARCH_CMD) ? ST_BIT : ST_IDLE;
                        end
                    end
                end
                ST_BIT: begin
                    if (slot_done) state <= ST_CMP;
                end
                ST_CMP: begin
                    if (slot_done) state <= ST_WR;
                end
                ST_WR: begin
                    if (slot_done) begin
                        if (slot_rx != own_bit) begin
                            state <= ST_OUT;
                        end else if (pos_q == POS_LAST) begin
                            state <= ST_FOUND;
                        end else begin
                            pos_q <= pos_q + 1'b1;
                            state <= ST_BIT;
                        end
                    end
                end
                default: state <= state;
            endcase
        end
    end

    // Slot control and status outputs decoded from the state
    always_comb begin
        slot_arm  = (state == ST_CMD) || (state == ST_BIT) ||
                    (state == ST_CMP) || (state == ST_WR);
        tx_en     = (state == ST_BIT) || (state == ST_CMP);
        tx_bit    = (state == ST_CMP) ? ~own_bit : own_bit;
        pres_pull = (state == ST_PRES_DRV);
        selected  = (state == ST_BIT) || (state == ST_CMP) ||
                    (state == ST_WR)  || (state == ST_FOUND);
    end
endmodule

// File: rtl/owire_search_slave.sv
// Top of the one-wire search responder. Joins the line monitor, the slot
// engine and the search controller, and merges the two pull-low sources.
// Assumes an external open-drain driver that pulls the line low while
// line_pull is high.
module owire_search_slave
    import owire_search_pkg::*;
#(
    parameter int ID_W        = 64,
    parameter int CLK_PER_US  = 50,
    parameter int RESET_US    = 480,
    parameter int PRES_GAP_US = 30,
    parameter int PRES_LEN_US = 120,
    parameter int SAMPLE_US   = 30,
    parameter int HOLD_US     = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            line_in,
    input  logic [ID_W-1:0] id_i,
    output logic            line_pull,
    output logic            selected
);
    localparam int RESET_CYC    = RESET_US * CLK_PER_US;
    localparam int PRES_GAP_CYC = PRES_GAP_US * CLK_PER_US;
    localparam int PRES_LEN_CYC = PRES_LEN_US * CLK_PER_US;
    localparam int SAMPLE_CYC   = SAMPLE_US * CLK_PER_US;
    localparam int HOLD_CYC     = HOLD_US * CLK_PER_US;

    logic      line_s;
    logic      fall;
    logic      rise;
    logic      reset_det;
    logic      slot_arm;
    logic      tx_en;
    logic      tx_bit;
    logic      slot_pull;
    logic      slot_done;
    logic      slot_rx;
    logic      pres_pull;
    ow_state_e state;

    owire_line_mon #(
        .RESET_CYC (RESET_CYC)
    ) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line_in),
        .line_s    (line_s),
        .fall      (fall),
        .rise      (rise),
        .reset_det (reset_det)
    );

    owire_slot #(
        .SAMPLE_CYC (SAMPLE_CYC),
        .HOLD_CYC   (HOLD_CYC)
    ) u_slot (
        .clk    (clk),
        .rst_n  (rst_n),
        .abort  (reset_det),
        .arm    (slot_arm),
        .fall   (fall),
        .line_s (line_s),
        .tx_en  (tx_en),
        .tx_bit (tx_bit),
        .pull   (slot_pull),
        .done   (slot_done),
        .rx_bit (slot_rx)
    );

    owire_search_fsm #(
        .ID_W         (ID_W),
        .PRES_GAP_CYC (PRES_GAP_CYC),
        .PRES_LEN_CYC (PRES_LEN_CYC)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .id_i      (id_i),
        .reset_det (reset_det),
        .rise      (rise),
        .slot_done (slot_done),
        .slot_rx   (slot_rx),
        .state     (state),
        .slot_arm  (slot_arm),
        .tx_en     (tx_en),
        .tx_bit    (tx_bit),
        .pres_pull (pres_pull),
        .selected  (selected)
    );

    // Merge the presence pulse and the read-slot drive onto the pull enable
    always_comb begin
        line_pull = pres_pull | slot_pull;
    end
endmodule

// File: rtl/owire_search_chk.sv
// Checker for the one-wire search responder, bound to the top module.
// Assumes the top's internal pull sources, slot completion and state are
// visible at the bind site.
module owire_search_chk
    import owire_search_pkg::*;
#(
    parameter int HOLD_CYC = 60,
    parameter int PRES_CYC = 240
) (
    input logic      clk,
    input logic      rst_n,
    input logic      selected,
    input logic      pres_pull,
    input logic      slot_pull,
    input logic      slot_done,
    input logic      reset_det,
    input ow_state_e state
);
    int unsigned slot_run;
    int unsigned pres_run;

    // Lengths of the current uninterrupted pull from each source
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_run <= 0;
            pres_run <= 0;
        end else begin
            slot_run <= slot_pull ? slot_run + 1 : 0;
            pres_run <= pres_pull ? pres_run + 1 : 0;
        end
    end

    assert_pres_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
        pres_pull |-> (pres_run < PRES_CYC));

    assert_one_source_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({pres_pull, slot_pull}));

    assert_sel_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(selected) |-> $past(slot_done));

    assert_sel_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(selected) |-> ($past(slot_done) || $past(reset_det)));

    assert_quiet_unsel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        slot_pull |-> selected);

    assert_found_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FOUND && !reset_det) |=> selected);

    assert_hold_len_R9: assert property (@(posedge clk) disable iff (!rst_n)
        slot_pull |-> (slot_run < HOLD_CYC));

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        reset_det |=> !selected);
endmodule

bind owire_search_slave owire_search_chk #(
    .HOLD_CYC (HOLD_CYC),
    .PRES_CYC (PRES_LEN_CYC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .selected  (selected),
    .pres_pull (pres_pull),
    .slot_pull (slot_pull),
    .slot_done (slot_done),
    .reset_det (reset_det),
    .state     (state)
);

// File: tb/sim_owire_search_slave.sv
// Directed bench for the one-wire search responder. It plays the bus master
// with a 2-cycles-per-microsecond time scale.
module sim_owire_search_slave;
    localparam int CPU  = 2;
    localparam int IDW  = 64;
    localparam logic [IDW-1:0] ID = 64'h8D3F_0A5C_E172_46B9;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           m_pull = 1'b0;
    logic           line;
    logic           line_pull;
    logic           selected;
    logic [IDW-1:0] id_in = ID;
    int             n_chk = 0;
    int             n_err = 0;
    bit             finished = 1'b0;

    always #5 clk = ~clk;

    assign line = ~(m_pull | line_pull);

    owire_search_slave #(
        .ID_W       (IDW),
        .CLK_PER_US (CPU)
    ) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_in   (line),
        .id_i      (id_in),
        .line_pull (line_pull),
        .selected  (selected)
    );

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Bus reset with presence checks; the presence pulse is low roughly 32..152 us after release
    task automatic ow_reset();
        m_pull = 1'b1;
        wait_cyc(500 * CPU);
        m_pull = 1'b0;
        wait_cyc(10 * CPU);
        check(line == 1'b1, "R1 no early presence", line, 1);
        check(selected == 1'b0, "R10 selected low after reset", selected, 0);
        wait_cyc(70 * CPU);
        check(line == 1'b0, "R1 presence low at 80us", line, 0);
        wait_cyc(120 * CPU);
        check(line == 1'b1, "R1 presence over at 200us", line, 1);
        wait_cyc(100 * CPU);
    endtask

    // Write slot: 0 holds low for 60 us, 1 for 3 us; slot length 70 us
    task automatic ow_write(input bit b);
        m_pull = 1'b1;
        wait_cyc(b ? 3 * CPU : 60 * CPU);
        m_pull = 1'b0;
        wait_cyc(b ? 67 * CPU : 10 * CPU);
    endtask

    // Read slot: master low for 3 us, samples at 15 us, checks R9 hold window
    task automatic ow_read(output bit v);
        m_pull = 1'b1;
        wait_cyc(3 * CPU);
        m_pull = 1'b0;
        wait_cyc(12 * CPU);
        v = line;
        wait_cyc(10 * CPU);
        check(line == v, "R9 level held at 25us", line, v);
        wait_cyc(20 * CPU);
        check(line == 1'b1, "R9 released by 45us", line, 1);
        wait_cyc(25 * CPU);
    endtask

    task automatic ow_cmd(input logic [7:0] c);
        for (int i = 0; i < 8; i++) ow_write(c[i]);
    endtask

    task automatic t_reset_state();
        rst_n = 1'b0;
        wait_cyc(5);
        check(line_pull == 1'b0, "R11 pull low in reset", line_pull, 0);
        check(selected == 1'b0, "R11 selected low in reset", selected, 0);
        rst_n = 1'b1;
        wait_cyc(20);
        check(line == 1'b1, "R11 line released after reset", line, 1);
    endtask

    task automatic t_wrong_cmd();
        bit v;
        ow_reset();
        ow_cmd(8'hCC);
        check(selected == 1'b0, "R4 other command not selected", selected, 0);
        for (int i = 0; i < 3; i++) begin
            ow_read(v);
            check(v == 1'b1, "R4 line released after other command", v, 1);
        end
        check(selected == 1'b0, "R4 still not selected", selected, 0);
    endtask

    // Search positions 0..n-1 with matching directions
    task automatic walk(input int n);
        bit a, b;
        for (int i = 0; i < n; i++) begin
            ow_read(a);
            check(a == ID[i], "R5 bit slot", a, ID[i]);
            ow_read(b);
            check(b == ~ID[i], "R6 complement slot", b, ~ID[i]);
            ow_write(ID[i]);
            check(selected == 1'b1, "R7 stays selected on match", selected, 1);
        end
    endtask

    task automatic t_full_pass();
        bit v;
        ow_reset();
        ow_cmd(8'hF0);
        check(selected == 1'b1, "R3 selected after search command", selected, 1);
        walk(IDW);
        check(selected == 1'b1, "R8 selected after all positions", selected, 1);
        for (int i = 0; i < 3; i++) begin
            ow_read(v);
            check(v == 1'b1, "R8 released after identification", v, 1);
        end
        ow_write(1'b0);
        check(selected == 1'b1, "R8 selected holds through slots", selected, 1);
    endtask

    task automatic t_mismatch();
        bit v;
        ow_reset();
        ow_cmd(8'hF0);
        walk(5);
        ow_read(v);
        check(v == ID[5], "R5 bit slot at position 5", v, ID[5]);
        ow_read(v);
        check(v == ~ID[5], "R6 complement at position 5", v, ~ID[5]);
        ow_write(~ID[5]);
        check(selected == 1'b0, "R7 deselected on mismatch", selected, 0);
        for (int i = 0; i < 4; i++) begin
            ow_read(v);
            check(v == 1'b1, "R7 released after mismatch", v, 1);
        end
        check(selected == 1'b0, "R7 stays deselected", selected, 0);
    endtask

    task automatic t_abort();
        bit v;
        ow_reset();
        ow_cmd(8'hF0);
        walk(3);
        ow_reset();
        check(selected == 1'b0, "R10 abort clears selected", selected, 0);
        ow_read(v);
        check(v == 1'b1, "R10 no search drive before command", v, 1);
        ow_reset();
        ow_cmd(8'hF0);
        check(selected == 1'b1, "R10 new search after abort", selected, 1);
        walk(2);
    endtask

    task automatic finish_run();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        t_reset_state();
        t_wrong_cmd();
        t_full_pass();
        t_mismatch();
        t_abort();
        finished = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: run did not complete actual=hung expected=done");
            finish_run();
        end
    end
endmodule